// File: doc/BRIEF.md
# Chained-Descriptor Streaming DMA Channel

This block is one DMA channel that streams data between a memory buffer and a fixed peripheral data register. Software builds a ring of link descriptors in memory, points the channel at the first one and launches it. The channel reads each descriptor over a 32-bit word memory port and moves the descriptor's byte count. It then follows the descriptor's next pointer. Because the last descriptor points back to the first, the stream runs with no further software action.

The address on the peripheral side can be held fixed, so a data register is accessed at 1, 2 or 4 bytes per beat. Narrow beats use byte enables in big-endian lane order. An external peripheral can hold off the start of the stream. It can also suspend the stream, and the channel checks for this only between bursts of a programmed size. Every finished segment sets a write-one-to-clear status bit and can raise an interrupt. Bad descriptors halt the channel with a programming-error flag.

Top module: `chain_dma`

## Requirements
- R1: After reset the status register reads zero, `irq` is low and `mem_req` is low. The channel never requests the memory port while it is idle (status bit 4, busy, clear).
- R2: A descriptor is four 32-bit words. At byte offset 0 is the source address, at 4 the destination address, at 8 the next pointer and at 12 the byte count. A segment moves exactly that many bytes, in beats taken from the source and written to the destination.
- R3: After a segment ends, the channel fetches the descriptor at that segment's next pointer. A ring of descriptors therefore repeats indefinitely.
- R4: Each finished segment sets status bit 0. `irq` is the OR of status bit 0 gated by mode bit 6 and status bit 1 gated by mode bit 7. Writing one to a status bit clears it, and `irq` falls at the clock edge that takes the write.
- R5: Mode bits 5:4 select the beat size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes. Mode bit 2 holds the source address and mode bit 3 holds the destination address. Within a word, byte offset k is carried on bits [31-8k -: 8], and the byte enables cover only those lanes (enable bit 3 is offset 0).
- R6: Any of these sets status bit 1 and status bit 5 (halted) and returns the channel to idle: a fetched byte count of zero, a next pointer whose low ALIGN bits are not zero, or beat size code 3.
- R7: If mode bit 8 is set at launch, the channel makes no memory request until `ext_start` is high.
- R8: If mode bit 9 is set, the channel samples `ext_pause` after every 2^(mode bits 15:12) bytes. While the input is high the channel waits, and a burst is never split.
- R9: Writing mode with bit 1 set stops the channel. On the next cycle it is idle with no request and the halted bit set.
- R10: A launch with mode bit 9 set while the count register (offset 5) is not zero sets status bit 1 and the channel does not start.
- R11: Register offsets 3, 4 and 5 read the next source address, the next destination address and the remaining byte count of the running segment.
- R12: `mem_req`, `mem_addr` and `mem_we` stay unchanged until `mem_gnt` is seen. A read completes on `mem_rvalid`.
- R13: Writing mode with bit 0 set while idle launches the channel. The channel fetches from the address held at register offset 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | AW | Word-aligned byte address |
| mem_be | output | 4 | Byte enables, bit 3 = lowest address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| ext_start | input | 1 | Peripheral start handshake |
| ext_pause | input | 1 | Peripheral pause handshake |
| irq | output | 1 | Interrupt |

## Verification
The bench builds the channel with a 16-bit address width and the default 32-byte descriptor alignment. This is enough to hold descriptors, buffers and a peripheral word at 0x300 in a 1 KB memory model. At run time the burst field is set to 4 bytes, which makes the pause boundary reachable after a single beat. A memory grant that can be withheld exposes the request-hold rule. A log of writes to the peripheral word makes the held-address lane and enable pattern observable.

// File: rtl/chain_dma.sv
module chain_dma #(
  parameter int AW    = 32,
  parameter int ALIGN = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  input  logic          ext_start,
  input  logic          ext_pause,
  output logic          irq
);
  typedef enum logic [3:0] {
    S_IDLE, S_WAIT, S_FREQ, S_FRSP, S_CHK, S_RREQ, S_RRSP, S_WREQ, S_PAUSE
  } st_t;

  st_t           st;
  logic [15:2]   mode_q;
  logic [AW-1:0] first_q, cur_q, src_q, dst_q, nxt_q;
  logic [31:0]   cnt_q, dat_q;
  logic [1:0]    idx_q;
  logic [16:0]   burst_q;
  logic          eos_q, perr_q, halt_q;

  logic src_hold, dst_hold, eos_ie, err_ie, xp_en;
  logic [1:0] code;
  assign src_hold = mode_q[2];
  assign dst_hold = mode_q[3];
  assign code     = mode_q[5:4];
  assign eos_ie   = mode_q[6];
  assign err_ie   = mode_q[7];
  assign xp_en    = mode_q[9];

  logic [3:0]  sz, be_base;
  logic [31:0] val_mask;
  logic [1:0]  rlane, wlane;
  logic [16:0] bwc_bytes, burst_nx;
  assign sz        = 4'd1 << code;
  assign be_base   = (code == 2'd0) ? 4'b0001 : (code == 2'd1) ? 4'b0011 : 4'b1111;
  assign val_mask  = (code == 2'd0) ? 32'h0000_00FF : (code == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  assign rlane     = 2'(3'd4 - {1'b0, src_q[1:0]} - sz[2:0]);
  assign wlane     = 2'(3'd4 - {1'b0, dst_q[1:0]} - sz[2:0]);
  assign bwc_bytes = 17'd1 << mode_q[15:12];
  assign burst_nx  = burst_q + 17'(sz);

  logic busy, launch, abort, bad_launch;
  assign busy       = (st != S_IDLE);
  assign abort      = reg_wr && (reg_addr == 3'd0) && reg_wdata[1];
  assign launch     = reg_wr && (reg_addr == 3'd0) && reg_wdata[0] && !busy;
  assign bad_launch = reg_wdata[9] && (cnt_q != 32'd0);

  assign irq       = (eos_q && eos_ie) || (perr_q && err_ie);
  assign mem_req   = (st == S_FREQ) || (st == S_RREQ) || (st == S_WREQ);
  assign mem_we    = (st == S_WREQ);
  assign mem_be    = (st == S_WREQ) ? (be_base << wlane) : 4'b1111;
  assign mem_wdata = (dat_q & val_mask) << {wlane, 3'b000};

  always_comb begin
    case (st)
      S_RREQ:  mem_addr = {src_q[AW-1:2], 2'b00};
      S_WREQ:  mem_addr = {dst_q[AW-1:2], 2'b00};
      default: mem_addr = cur_q + AW'({idx_q, 2'b00});
    endcase
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {16'd0, mode_q, 2'b00};
      3'd1:    reg_rdata = {26'd0, halt_q, busy, 2'b00, perr_q, eos_q};
      3'd2:    reg_rdata = 32'(first_q);
      3'd3:    reg_rdata = 32'(src_q);
      3'd4:    reg_rdata = 32'(dst_q);
      3'd5:    reg_rdata = cnt_q;
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      mode_q <= '0;
      first_q <= '0;
      cur_q <= '0;
      src_q <= '0;
      dst_q <= '0;
      nxt_q <= '0;
      cnt_q <= '0;
      dat_q <= '0;
      idx_q <= '0;
      burst_q <= '0;
      eos_q <= 1'b0;
      perr_q <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          3'd0: mode_q <= reg_wdata[15:2];
          3'd1: begin
            eos_q  <= eos_q & ~reg_wdata[0];
            perr_q <= perr_q & ~reg_wdata[1];
          end
          3'd2: first_q <= reg_wdata[AW-1:0];
          3'd5: if (!busy) cnt_q <= reg_wdata;
          default: ;
        endcase
      end
      if (abort) begin
        st <= S_IDLE;
        halt_q <= 1'b1;
      end else begin
        case (st)
          S_IDLE: if (launch) begin
            if (bad_launch) begin
              perr_q <= 1'b1;
              halt_q <= 1'b1;
            end else begin
              halt_q <= 1'b0;
              cur_q <= first_q;
              idx_q <= '0;
              st <= reg_wdata[8] ? S_WAIT : S_FREQ;
            end
          end
          S_WAIT: if (ext_start) st <= S_FREQ;
          S_FREQ: if (mem_gnt) st <= S_FRSP;
          S_FRSP: if (mem_rvalid) begin
            case (idx_q)
              2'd0: src_q <= mem_rdata[AW-1:0];
              2'd1: dst_q <= mem_rdata[AW-1:0];
              2'd2: nxt_q <= mem_rdata[AW-1:0];
              default: cnt_q <= mem_rdata;
            endcase
            idx_q <= idx_q + 2'd1;
            st <= (idx_q == 2'd3) ? S_CHK : S_FREQ;
          end
          S_CHK: begin
            burst_q <= '0;
            if (cnt_q == 32'd0 || nxt_q[ALIGN-1:0] != '0 || code == 2'd3) begin
              perr_q <= 1'b1;
              halt_q <= 1'b1;
              st <= S_IDLE;
            end else begin
              st <= S_RREQ;
            end
          end
          S_RREQ: if (mem_gnt) st <= S_RRSP;
          S_RRSP: if (mem_rvalid) begin
            dat_q <= (mem_rdata >> {rlane, 3'b000}) & val_mask;
            st <= S_WREQ;
          end
          S_WREQ: if (mem_gnt) begin
            if (!src_hold) src_q <= src_q + AW'(sz);
            if (!dst_hold) dst_q <= dst_q + AW'(sz);
            if (cnt_q <= 32'(sz)) begin
              cnt_q <= '0;
              eos_q <= 1'b1;
              cur_q <= nxt_q;
              idx_q <= '0;
              st <= S_FREQ;
            end else begin
              cnt_q <= cnt_q - 32'(sz);
              if (burst_nx >= bwc_bytes) begin
                burst_q <= '0;
                st <= (xp_en && ext_pause) ? S_PAUSE : S_RREQ;
              end else begin
                burst_q <= burst_nx;
                st <= S_RREQ;
              end
            end
          end
          S_PAUSE: if (!ext_pause) st <= S_RREQ;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module chain_dma_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [2:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_gnt,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    mem_be,
  input logic          busy,
  input logic          perr
);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R9
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 3'd0 && reg_wdata[1] |=> !mem_req && !busy);

  // R5
  lane_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4));

  // R6
  perr_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perr) |-> !busy);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
endmodule

bind chain_dma chain_dma_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
  .mem_gnt(mem_gnt), .mem_addr(mem_addr), .mem_be(mem_be),
  .busy(busy), .perr(perr_q)
);

// File: tb/chain_dma_tb.sv
module chain_dma_tb;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata;
  logic mem_gnt = 1'b1;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic ext_start = 1'b0;
  logic ext_pause = 1'b0;
  logic irq;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] mem [0:255];
  logic [31:0] log_d [0:63];
  logic [3:0]  log_b [0:63];
  int log_n = 0;

  always #4 clk = ~clk;

  chain_dma #(.AW(AW), .ALIGN(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .ext_start(ext_start), .ext_pause(ext_pause),
    .irq(irq)
  );

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (rst_n && mem_req && mem_gnt) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        if (mem_addr[9:2] == 8'hC0 && log_n < 64) begin
          log_d[log_n] <= mem_wdata;
          log_b[log_n] <= mem_be;
          log_n <= log_n + 1;
        end
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata <= mem[mem_addr[9:2]];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_irq(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 400 && !seen; i++) begin
      @(negedge clk);
      if (irq) seen = 1'b1;
    end
  endtask

  task automatic put_desc(input int w, input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] n, input logic [31:0] c);
    mem[w] = s; mem[w+1] = d; mem[w+2] = n; mem[w+3] = c;
  endtask

  task automatic setup();
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    put_desc(0, 32'h100, 32'h300, 32'h020, 32'd8);
    put_desc(8, 32'h108, 32'h300, 32'h000, 32'd8);
    mem[8'h40] = 32'hA0A1A2A3; mem[8'h41] = 32'hB0B1B2B3;
    mem[8'h42] = 32'hC0C1C2C3; mem[8'h43] = 32'hD0D1D2D3;
    wr_reg(3'd0, 32'h2);
    wr_reg(3'd5, 32'h0);
    wr_reg(3'd1, 32'h3);
    log_n = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd_reg(3'd1, v);
    chk(v == 32'h0, "R1", "status after reset", v, 32'h0);
    chk(irq == 1'b0, "R1", "irq after reset", 32'(irq), 32'h0);
    chk(mem_req == 1'b0, "R1", "mem_req after reset", 32'(mem_req), 32'h0);
  endtask

  task automatic t_ring();
    bit seen;
    logic [31:0] v;
    setup();
    wr_reg(3'd2, 32'h0);
    wr_reg(3'd0, 32'hF069);
    wait_irq(seen);
    chk(seen, "R4", "irq after first segment", 32'(seen), 32'h1);
    chk(log_n == 2, "R2", "beats in segment", 32'(log_n), 32'd2);
    chk(log_d[0] == 32'hA0A1A2A3 && log_d[1] == 32'hB0B1B2B3, "R2", "segment A data", log_d[1], 32'hB0B1B2B3);
    chk(log_b[0] == 4'hF, "R5", "word enables", 32'(log_b[0]), 32'hF);
    rd_reg(3'd1, v);
    chk(v[0] == 1'b1, "R4", "end-of-segment bit", v, 32'h1);
    wr_reg(3'd1, 32'h1);
    chk(irq == 1'b0, "R4", "irq after clear", 32'(irq), 32'h0);
    wait_irq(seen);
    chk(seen && log_d[2] == 32'hC0C1C2C3 && log_d[3] == 32'hD0D1D2D3, "R3", "segment B data", log_d[3], 32'hD0D1D2D3);
    wr_reg(3'd1, 32'h1);
    wait_irq(seen);
    chk(seen && log_d[4] == 32'hA0A1A2A3 && log_d[5] == 32'hB0B1B2B3, "R3", "ring wrap data", log_d[5], 32'hB0B1B2B3);
    wr_reg(3'd0, 32'h2);
    rd_reg(3'd4, v);
    chk(v == 32'h300, "R11", "held destination readback", v, 32'h300);
  endtask

  task automatic t_narrow();
    bit seen;
    setup();
    put_desc(16, 32'h100, 32'h302, 32'h040, 32'd4);
    wr_reg(3'd2, 32'h40);
    wr_reg(3'd0, 32'hF059);
    wait_irq(seen);
    wr_reg(3'd0, 32'h2);
    chk(seen && log_b[0] == 4'b0011 && log_b[1] == 4'b0011, "R5", "16-bit lane enables", 32'(log_b[0]), 32'h3);
    chk(log_d[0][15:0] == 16'hA0A1 && log_d[1][15:0] == 16'hA2A3, "R5", "16-bit lane data",
        {log_d[0][15:0], log_d[1][15:0]}, 32'hA0A1A2A3);
    setup();
    mem[8'hC0] = 32'h11223344;
    put_desc(24, 32'h303, 32'h200, 32'h060, 32'd4);
    wr_reg(3'd2, 32'h60);
    wr_reg(3'd0, 32'hF045);
    wait_irq(seen);
    wr_reg(3'd0, 32'h2);
    chk(seen && mem[8'h80] == 32'h44444444, "R5", "held byte source capture", mem[8'h80], 32'h44444444);
  endtask

  task automatic t_perr();
    bit seen;
    logic [31:0] v;
    setup();
    put_desc(40, 32'h100, 32'h300, 32'h000, 32'd0);
    wr_reg(3'd2, 32'hA0);
    wr_reg(3'd0, 32'h81);
    wait_irq(seen);
    rd_reg(3'd1, v);
    chk(seen && v[1] && v[5] && !v[4], "R6", "zero count error", v, 32'h22);
    wr_reg(3'd1, 32'h2);
    chk(irq == 1'b0, "R4", "irq after error clear", 32'(irq), 32'h0);
    put_desc(48, 32'h100, 32'h300, 32'h024, 32'd8);
    wr_reg(3'd2, 32'hC0);
    wr_reg(3'd0, 32'h1);
    repeat (30) @(negedge clk);
    rd_reg(3'd1, v);
    chk(v[1] && !v[4], "R6", "misaligned next error", v, 32'h22);
    chk(irq == 1'b0, "R6", "error irq gated off", 32'(irq), 32'h0);
    wr_reg(3'd1, 32'h3);
    wr_reg(3'd2, 32'h0);
    wr_reg(3'd0, 32'hF0B9);
    wait_irq(seen);
    rd_reg(3'd1, v);
    chk(seen && v[1] && log_n == 0, "R6", "size code 3 error", v, 32'h22);
    wr_reg(3'd1, 32'h3);
  endtask

  task automatic t_start();
    bit seen;
    logic [31:0] v;
    bit quiet = 1'b1;
    setup();
    wr_reg(3'd2, 32'h0);
    wr_reg(3'd0, 32'hF169);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (mem_req) quiet = 1'b0;
    end
    rd_reg(3'd1, v);
    chk(quiet && v[4], "R7", "held before ext_start", v, 32'h10);
    ext_start = 1'b1;
    wait_irq(seen);
    chk(seen && log_n >= 2, "R7", "runs after ext_start", 32'(log_n), 32'd2);
    wr_reg(3'd0, 32'h2);
    ext_start = 1'b0;
  endtask

  task automatic t_pause();
    bit seen;
    logic [31:0] v;
    setup();
    wr_reg(3'd2, 32'h0);
    ext_pause = 1'b1;
    wr_reg(3'd0, 32'h2269);
    repeat (40) @(negedge clk);
    chk(log_n == 1, "R8", "one burst before pause", 32'(log_n), 32'd1);
    rd_reg(3'd3, v);
    chk(v == 32'h104, "R11", "source position", v, 32'h104);
    rd_reg(3'd5, v);
    chk(v == 32'd4, "R11", "remaining count", v, 32'd4);
    ext_pause = 1'b0;
    wait_irq(seen);
    chk(seen && log_n == 2 && log_d[1] == 32'hB0B1B2B3, "R8", "resume after pause", log_d[1], 32'hB0B1B2B3);
    wr_reg(3'd0, 32'h2);
  endtask

  task automatic t_abort_and_count();
    logic [31:0] v;
    setup();
    wr_reg(3'd2, 32'h0);
    wr_reg(3'd0, 32'hF069);
    repeat (5) @(negedge clk);
    wr_reg(3'd0, 32'hF06A);
    rd_reg(3'd1, v);
    chk(!v[4] && v[5] && !mem_req, "R9", "abort stops channel", v, 32'h20);
    setup();
    wr_reg(3'd5, 32'd8);
    wr_reg(3'd0, 32'h0281);
    rd_reg(3'd1, v);
    chk(v[1] && !v[4] && irq, "R10", "nonzero count with pause", v, 32'h22);
    wr_reg(3'd5, 32'd0);
    wr_reg(3'd1, 32'h3);
  endtask

  task automatic t_grant();
    bit seen;
    bit held = 1'b1;
    setup();
    wr_reg(3'd2, 32'h20);
    mem_gnt = 1'b0;
    wr_reg(3'd0, 32'hF069);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (!mem_req || mem_addr != 16'h20) held = 1'b0;
    end
    chk(held, "R12", "request held without grant", 32'(mem_addr), 32'h20);
    mem_gnt = 1'b1;
    wait_irq(seen);
    chk(seen && log_d[0] == 32'hC0C1C2C3, "R13", "launch from first pointer", log_d[0], 32'hC0C1C2C3);
    wr_reg(3'd0, 32'h2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog expired: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ring();
    t_narrow();
    t_perr();
    t_start();
    t_pause();
    t_abort_and_count();
    t_grant();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule